// File: doc/BRIEF.md
# Fuse array read controller

This block lets software read a one-time-programmable fuse array of 1024 bytes through a small 32-bit register file. Registers sit at word stride. Software first sets the read timing in the configuration register. It then writes the control register with a start byte address, a length-minus-one and the read-enable bit. The controller drives the fuse macro's 9-bit address and runs a strobe whose timing is set in whole clock cycles. It then captures one 256-bit row into eight 32-bit data registers and raises a sticky done flag, which software polls.

The read window has two software-set counts: an address-setup count and a strobe count, each 4 bits. The setup phase lasts (setup + 1) cycles before the strobe rises. The row is sampled (setup + 5 + strobe) cycles after the read starts. Bytes past the requested length read back as zero.

Program and write requests are accepted but do nothing. There is no burn path.

Top module: `fuse_read_ctrl`

## Requirements
- R1: After reset every register reads zero, and `irq` and `fuse_strobe` are low.
- R2: A control write (word 0) with bit 0 set, made while no read is running, starts a read. During the read `fuse_addr` equals bits [9:1] of the start address. The start address is held in control bits [30:21] and the length-minus-one in bits [20:16].
- R3: `fuse_strobe` is low for the first (A + 1) cycles after the start edge and then high until the sample edge. The sample edge comes (A + 5 + S) edges after the start edge. A is configuration bits [23:20] and S is configuration bits [19:16], both latched when the read starts.
- R4: Status bit 0 sets on the sample edge and stays set. It clears on the edge that starts the next read. Control bit 0 reads 1 during a read and 0 once the read is done.
- R5: Data word n (word index 3 + n, n = 0..7) holds chunk bytes 4n..4n+3, with byte k at bits [8(k mod 4)+7 : 8(k mod 4)]. Chunk byte k is taken from `fuse_rdata[8k+7:8k]`.
- R6: Chunk bytes with index greater than the length-minus-one field read zero.
- R7: Control writes made while a read is running are ignored in full. The stored address and length do not change, and no new read starts.
- R8: Writes to the status word (2) and the data words (3..10) are ignored. The data words keep their value until the next read completes.
- R9: `irq` is high exactly when configuration bit 31 is set and status bit 0 is set.
- R10: A control write with program enable (bit 15) and/or write enable (bit 1), but without bit 0, causes no strobe and leaves the data words unchanged. Status bit 1 stays 0. Control bit 1 always reads 0, while bit 15 reads back as written.
- R11: The configuration word reads back bits 31 and [23:0] as written, with all other bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wen | input | 1 | Register write strobe |
| reg_ren | input | 1 | Register read strobe; `reg_rdata` is valid on the following cycle |
| reg_idx | input | 4 | Register word index (byte offset / 4) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| fuse_addr | output | 9 | Row address to the fuse macro |
| fuse_strobe | output | 1 | Read strobe to the fuse macro |
| fuse_rdata | input | 256 | Row data from the fuse macro, 32 bytes |
| irq | output | 1 | Read-done interrupt |

## Verification
The assertions assume that reset is held high through the first clock edge. They also assume that a read can only be started through the control register, and only while the controller is idle. The bench keeps to this: it drives every register access on the falling edge and makes one access at a time. It also holds the behavioural fuse array fixed, so `fuse_rdata` depends only on `fuse_addr`. Random reads use a fixed seed and draw setup counts, strobe counts, addresses, lengths and the interrupt enable. They are mixed with directed cases at the count extremes, at the top of the array, at an odd start address and with control writes issued mid-read.

// File: rtl/fuse_rd_pkg.sv
package fuse_rd_pkg;
  // register word indices
  localparam int IDX_CTRL  = 0;
  localparam int IDX_CFG   = 1;
  localparam int IDX_STAT  = 2;
  localparam int IDX_DATA0 = 3;
  // control fields
  localparam int CTL_RD_BIT   = 0;
  localparam int CTL_WR_BIT   = 1;
  localparam int CTL_PG_BIT   = 15;
  localparam int CTL_LEN_LSB  = 16;
  localparam int CTL_ADDR_LSB = 21;
  // configuration fields
  localparam int CFG_WSTRB_LSB = 0;
  localparam int CFG_WSTRB_W   = 12;
  localparam int CFG_WADJ_LSB  = 12;
  localparam int CFG_WADJ_W    = 4;
  localparam int CFG_RSTRB_LSB = 16;
  localparam int CFG_RADJ_LSB  = 20;
  localparam int CFG_IE_BIT    = 31;
endpackage

// File: rtl/fuse_rd_seq.sv
module fuse_rd_seq #(
  parameter int ADJ_W  = 4,
  parameter int STRB_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADJ_W-1:0]  rd_adj,
  input  logic [STRB_W-1:0] rd_strb,
  output logic              busy,
  output logic              done,
  output logic              sample,
  output logic              fuse_strobe
);
  localparam int CNT_W = $clog2((1 << ADJ_W) + (1 << STRB_W) + 4);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_q;
  logic [CNT_W-1:0] adj_q;

  assign sample = busy && (cnt_q == last_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy        <= 1'b0;
      done        <= 1'b0;
      fuse_strobe <= 1'b0;
      cnt_q       <= '0;
      last_q      <= '0;
      adj_q       <= '0;
    end else if (start) begin
      busy        <= 1'b1;
      done        <= 1'b0;
      fuse_strobe <= 1'b0;
      cnt_q       <= '0;
      adj_q       <= CNT_W'(rd_adj);
      last_q      <= CNT_W'(rd_adj) + CNT_W'(rd_strb) + CNT_W'(4);
    end else if (busy) begin
      if (cnt_q == last_q) begin
        busy        <= 1'b0;
        done        <= 1'b1;
        fuse_strobe <= 1'b0;
      end else begin
        cnt_q       <= cnt_q + 1'b1;
        fuse_strobe <= (cnt_q >= adj_q);
      end
    end
  end
endmodule

// File: rtl/fuse_rd_capture.sv
module fuse_rd_capture #(
  parameter int NWORDS = 8,
  parameter int LEN_W  = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sample,
  input  logic [LEN_W-1:0]      len_m1,
  input  logic [NWORDS*32-1:0]  fuse_rdata,
  output logic [NWORDS*32-1:0]  data_flat
);
  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    for (genvar b = 0; b < 4; b++) begin : g_byte
      localparam int K = w * 4 + b;
      always_ff @(posedge clk) begin
        if (rst)
          data_flat[8*K +: 8] <= '0;
        else if (sample)
          data_flat[8*K +: 8] <= (K <= int'(len_m1)) ? fuse_rdata[8*K +: 8] : 8'h00;
      end
    end
  end
endmodule

// File: rtl/fuse_rd_regs.sv
module fuse_rd_regs
  import fuse_rd_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LEN_W  = 5,
  parameter int ADJ_W  = 4,
  parameter int STRB_W = 4,
  parameter int NWORDS = 8,
  parameter int IDX_W  = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_wen,
  input  logic                 reg_ren,
  input  logic [IDX_W-1:0]     reg_idx,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic                 busy,
  input  logic                 done,
  input  logic                 sample,
  input  logic [NWORDS*32-1:0] data_flat,
  output logic                 start,
  output logic [ADDR_W-1:0]    start_addr,
  output logic [LEN_W-1:0]     len_m1,
  output logic                 int_en,
  output logic [ADJ_W-1:0]     rd_adj,
  output logic [STRB_W-1:0]    rd_strb
);
  logic                   pg_q;
  logic                   rd_q;
  logic [CFG_WADJ_W-1:0]  wr_adj_q;
  logic [CFG_WSTRB_W-1:0] wr_strb_q;
  logic                   ctrl_acc;
  logic [31:0]            ctrl_word;
  logic [31:0]            cfg_word;
  logic [IDX_W-1:0]       dsel;

  assign ctrl_acc = reg_wen && (reg_idx == IDX_W'(IDX_CTRL)) && !busy;
  assign start    = ctrl_acc && reg_wdata[CTL_RD_BIT];
  assign dsel     = reg_idx - IDX_W'(IDX_DATA0);

  always_ff @(posedge clk) begin
    if (rst) begin
      start_addr <= '0;
      len_m1     <= '0;
      pg_q       <= 1'b0;
      rd_q       <= 1'b0;
      int_en     <= 1'b0;
      rd_adj     <= '0;
      rd_strb    <= '0;
      wr_adj_q   <= '0;
      wr_strb_q  <= '0;
    end else begin
      if (ctrl_acc) begin
        start_addr <= reg_wdata[CTL_ADDR_LSB +: ADDR_W];
        len_m1     <= reg_wdata[CTL_LEN_LSB +: LEN_W];
        pg_q       <= reg_wdata[CTL_PG_BIT];
        rd_q       <= reg_wdata[CTL_RD_BIT];
      end else if (sample) begin
        rd_q <= 1'b0;
      end
      if (reg_wen && (reg_idx == IDX_W'(IDX_CFG))) begin
        int_en    <= reg_wdata[CFG_IE_BIT];
        rd_adj    <= reg_wdata[CFG_RADJ_LSB +: ADJ_W];
        rd_strb   <= reg_wdata[CFG_RSTRB_LSB +: STRB_W];
        wr_adj_q  <= reg_wdata[CFG_WADJ_LSB +: CFG_WADJ_W];
        wr_strb_q <= reg_wdata[CFG_WSTRB_LSB +: CFG_WSTRB_W];
      end
    end
  end

  always_comb begin
    ctrl_word = '0;
    ctrl_word[CTL_ADDR_LSB +: ADDR_W] = start_addr;
    ctrl_word[CTL_LEN_LSB +: LEN_W]   = len_m1;
    ctrl_word[CTL_PG_BIT]             = pg_q;
    ctrl_word[CTL_RD_BIT]             = rd_q;
    cfg_word = '0;
    cfg_word[CFG_IE_BIT]                     = int_en;
    cfg_word[CFG_RADJ_LSB +: ADJ_W]          = rd_adj;
    cfg_word[CFG_RSTRB_LSB +: STRB_W]        = rd_strb;
    cfg_word[CFG_WADJ_LSB +: CFG_WADJ_W]     = wr_adj_q;
    cfg_word[CFG_WSTRB_LSB +: CFG_WSTRB_W]   = wr_strb_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_ren) begin
      if (reg_idx == IDX_W'(IDX_CTRL))
        reg_rdata <= ctrl_word;
      else if (reg_idx == IDX_W'(IDX_CFG))
        reg_rdata <= cfg_word;
      else if (reg_idx == IDX_W'(IDX_STAT))
        reg_rdata <= {31'd0, done};
      else if (int'(reg_idx) >= IDX_DATA0 && int'(reg_idx) < IDX_DATA0 + NWORDS)
        reg_rdata <= data_flat[32*dsel +: 32];
      else
        reg_rdata <= '0;
    end
  end
endmodule

// File: rtl/fuse_read_ctrl.sv
module fuse_read_ctrl #(
  parameter int ADDR_W = 10,
  parameter int LEN_W  = 5,
  parameter int ADJ_W  = 4,
  parameter int STRB_W = 4,
  parameter int NWORDS = 8,
  parameter int IDX_W  = 4,
  localparam int FADDR_W = ADDR_W - 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_wen,
  input  logic                 reg_ren,
  input  logic [IDX_W-1:0]     reg_idx,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  output logic [FADDR_W-1:0]   fuse_addr,
  output logic                 fuse_strobe,
  input  logic [NWORDS*32-1:0] fuse_rdata,
  output logic                 irq
);
  logic                 start;
  logic                 busy;
  logic                 done;
  logic                 sample;
  logic [ADDR_W-1:0]    start_addr;
  logic [LEN_W-1:0]     len_m1;
  logic                 int_en;
  logic [ADJ_W-1:0]     rd_adj;
  logic [STRB_W-1:0]    rd_strb;
  logic [NWORDS*32-1:0] data_flat;

  fuse_rd_regs #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .ADJ_W(ADJ_W),
    .STRB_W(STRB_W), .NWORDS(NWORDS), .IDX_W(IDX_W)
  ) i_regs (
    .clk(clk), .rst(rst), .reg_wen(reg_wen), .reg_ren(reg_ren),
    .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .busy(busy), .done(done), .sample(sample), .data_flat(data_flat),
    .start(start), .start_addr(start_addr), .len_m1(len_m1),
    .int_en(int_en), .rd_adj(rd_adj), .rd_strb(rd_strb)
  );

  fuse_rd_seq #(.ADJ_W(ADJ_W), .STRB_W(STRB_W)) i_seq (
    .clk(clk), .rst(rst), .start(start), .rd_adj(rd_adj), .rd_strb(rd_strb),
    .busy(busy), .done(done), .sample(sample), .fuse_strobe(fuse_strobe)
  );

  fuse_rd_capture #(.NWORDS(NWORDS), .LEN_W(LEN_W)) i_cap (
    .clk(clk), .rst(rst), .sample(sample), .len_m1(len_m1),
    .fuse_rdata(fuse_rdata), .data_flat(data_flat)
  );

  assign fuse_addr = start_addr[ADDR_W-1:1];
  assign irq       = int_en & done;
endmodule

// File: rtl/fuse_rd_chk.sv
module fuse_rd_chk #(
  parameter int FADDR_W = 9
) (
  input logic               clk,
  input logic               rst,
  input logic               start,
  input logic               busy,
  input logic               done,
  input logic               fuse_strobe,
  input logic [FADDR_W-1:0] fuse_addr,
  input logic               irq
);
  a_r3_strobe_in_read: assert property (@(posedge clk) disable iff (rst)
    fuse_strobe |-> busy);

  a_r3_strobe_ends_at_sample: assert property (@(posedge clk) disable iff (rst)
    $fell(fuse_strobe) |-> $rose(done));

  a_r4_done_clears_on_start: assert property (@(posedge clk) disable iff (rst)
    start |=> !done);

  a_r4_done_sticky: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);

  a_r7_start_only_idle: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);

  a_r2_addr_held: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(fuse_addr));

  a_r9_irq_needs_done: assert property (@(posedge clk) disable iff (rst)
    irq |-> done);
endmodule

bind fuse_read_ctrl fuse_rd_chk #(.FADDR_W(FADDR_W)) i_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .fuse_strobe(fuse_strobe), .fuse_addr(fuse_addr), .irq(irq)
);

// File: tb/test_fuse_read_ctrl.sv
module test_fuse_read_ctrl;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         reg_wen = 1'b0;
  logic         reg_ren = 1'b0;
  logic [3:0]   reg_idx = '0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic [8:0]   fuse_addr;
  logic         fuse_strobe;
  logic [255:0] fuse_rdata;
  logic         irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  logic [7:0] fmem [0:1023];

  always #2.5 clk = ~clk;

  fuse_read_ctrl i_fuse_read_ctrl (
    .clk(clk), .rst(rst), .reg_wen(reg_wen), .reg_ren(reg_ren),
    .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .fuse_addr(fuse_addr), .fuse_strobe(fuse_strobe),
    .fuse_rdata(fuse_rdata), .irq(irq)
  );

  // behavioural fuse macro: row byte k comes from array byte {addr,0}+k
  always_comb begin
    for (int k = 0; k < 32; k++) begin
      logic [9:0] ba;
      ba = {fuse_addr, 1'b0} + 10'(k);
      fuse_rdata[8*k +: 8] = fmem[ba];
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input int idx, input logic [31:0] d);
    @(negedge clk);
    reg_wen = 1'b1; reg_idx = 4'(idx); reg_wdata = d;
    @(negedge clk);
    reg_wen = 1'b0;
  endtask

  task automatic bus_read(input int idx, output logic [31:0] d);
    @(negedge clk);
    reg_ren = 1'b1; reg_idx = 4'(idx);
    @(negedge clk);
    reg_ren = 1'b0;
    d = reg_rdata;
  endtask

  function automatic logic [31:0] exp_word(logic [9:0] a, logic [4:0] len, int w);
    logic [31:0] r;
    r = '0;
    for (int b = 0; b < 4; b++) begin
      int k;
      logic [9:0] ba;
      k = w * 4 + b;
      ba = {a[9:1], 1'b0} + 10'(k);
      if (k <= int'(len)) r[8*b +: 8] = fmem[ba];
    end
    return r;
  endfunction

  function automatic logic [31:0] cfg_val(int adj, int strb, bit ie);
    return {ie, 7'd0, 4'(adj), 4'(strb), 16'd0};
  endfunction

  function automatic logic [31:0] ctrl_val(logic [9:0] a, logic [4:0] len, bit rd);
    return {1'b0, a, len, 15'd0, rd};
  endfunction

  task automatic verify_data(input logic [9:0] a, input logic [4:0] len, input string req);
    logic [31:0] d;
    for (int w = 0; w < 8; w++) begin
      bus_read(3 + w, d);
      check(req, d, exp_word(a, len, w));
    end
  endtask

  // full read: config, start, cycle-exact timing (R3, R2, R9), data (R5/R6), status (R4)
  task automatic do_read(input int adj, input int strb, input logic [9:0] a,
                         input logic [4:0] len, input bit ie);
    int total, errs;
    logic [31:0] d;
    bus_write(1, cfg_val(adj, strb, ie));
    bus_write(0, ctrl_val(a, len, 1'b1));
    total = adj + 5 + strb;
    errs = 0;
    for (int k = 0; k <= total; k++) begin
      bit es, ei;
      es = (k >= adj + 1) && (k <= total - 1);
      ei = ie && (k >= total);
      if (fuse_strobe !== es) errs++;
      if (irq !== ei) errs++;
      if (k < total && fuse_addr !== a[9:1]) errs++;
      if (k < total) @(negedge clk);
    end
    check("R3 strobe/sample timing, R2 address, R9 irq", 32'(errs), 32'd0);
    verify_data(a, len, (len == 5'd31) ? "R5 data" : "R6 length mask");
    bus_read(2, d);
    check("R4 done set", d, 32'd1);
    bus_read(0, d);
    check("R4 read enable self-clears", d, ctrl_val(a, len, 1'b0));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd1234));
    for (int i = 0; i < 1024; i++) fmem[i] = 8'($urandom);

    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 strobe", {31'd0, fuse_strobe}, 32'd0);
    for (int i = 0; i < 11; i++) begin
      bus_read(i, d);
      check("R1 register zero", d, 32'd0);
    end

    // R11 config readback
    bus_write(1, 32'hFFFF_FFFF);
    bus_read(1, d);
    check("R11 cfg readback", d, 32'h80FF_FFFF);
    bus_write(1, 32'h5A5A_5A5A);
    bus_read(1, d);
    check("R11 cfg readback", d, 32'h005A_5A5A);

    // directed corners of R3/R5
    do_read(0, 0, 10'd0, 5'd31, 1'b1);
    do_read(15, 15, 10'd992, 5'd31, 1'b1);
    // R6 short length at an odd address
    do_read(2, 3, 10'd5, 5'd0, 1'b1);
    do_read(1, 1, 10'd1023, 5'd13, 1'b0);

    // R9 enabling the interrupt after completion raises irq at once
    bus_write(1, cfg_val(1, 1, 1'b1));
    check("R9 irq follows enable", {31'd0, irq}, 32'd1);
    bus_write(1, cfg_val(1, 1, 1'b0));
    check("R9 irq follows disable", {31'd0, irq}, 32'd0);

    // R7 control write mid-read is ignored
    bus_write(1, cfg_val(10, 10, 1'b0));
    bus_write(0, ctrl_val(10'd64, 5'd31, 1'b1));
    bus_write(0, ctrl_val(10'd512, 5'd3, 1'b1));
    repeat (40) @(negedge clk);
    bus_read(0, d);
    check("R7 ctrl unchanged", d, ctrl_val(10'd64, 5'd31, 1'b0));
    verify_data(10'd64, 5'd31, "R7 data from first request");

    // R4 done clears on a new start
    bus_write(0, ctrl_val(10'd96, 5'd31, 1'b1));
    bus_read(2, d);
    check("R4 done cleared by start", d, 32'd0);
    repeat (40) @(negedge clk);
    bus_read(2, d);
    check("R4 done after completion", d, 32'd1);

    // R8 writes to status and data ignored
    bus_write(2, 32'h0);
    bus_read(2, d);
    check("R8 status write ignored", d, 32'd1);
    for (int w = 0; w < 8; w++) bus_write(3 + w, 32'hDEAD_BEEF);
    verify_data(10'd96, 5'd31, "R8 data write ignored");

    // R10 program / write enable: no strobe, no data change, no write-done
    begin
      int strobes;
      strobes = 0;
      bus_write(0, 32'h0000_8002 | ctrl_val(10'd200, 5'd31, 1'b0));
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (fuse_strobe) strobes++;
      end
      check("R10 no strobe", 32'(strobes), 32'd0);
      bus_read(2, d);
      check("R10 write-done stays 0", d, 32'd1);
      bus_read(0, d);
      check("R10 ctrl readback", d, 32'h0000_8000 | ctrl_val(10'd200, 5'd31, 1'b0));
      verify_data(10'd96, 5'd31, "R10 data unchanged");
    end

    // random reads
    for (int it = 0; it < 25; it++) begin
      do_read(int'($urandom_range(0, 15)), int'($urandom_range(0, 15)),
              10'($urandom), 5'($urandom), 1'($urandom));
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule